// File: doc/BRIEF.md
# Up/Down Timer Counter Core

This block is the counting heart of a general-purpose timer. A free-running tick input is thinned by a programmable prescaler. Every PSC+1 accepted ticks, one counter step is produced. That step drives a 16-bit counter with three ways of counting. It can count upward from zero to the reload limit. It can count downward from the reload limit to zero. It can also sweep up and down between the two ends, in center-aligned fashion.

Each time a counting cycle ends, the counter restarts and an update pulse is raised. A copy of that pulse is driven out as a trigger, for neighbouring timers or converters. The prescale divisor and the reload limit are written into holding registers. They move into the working registers only on an update. A software update request forces that transfer at once, restarts the counter and clears the prescaler. There is no repetition counter, so every cycle end produces an update.

Software reaches the block through a simple write port. Select code 0 is the control word, code 1 the prescale divisor, code 2 the reload limit, and code 3 is ignored. Control word bits: bit 0 run, bits 2:1 counting mode, bit 3 update request.

Top module: `utmr_core`

## Requirements
- R1: After a synchronous reset, count_out, dir_out, upd_out and trig_out are 0, the working and holding prescale values are 0, and the working and holding reload limits are all ones.
- R2: The counter moves only while run (control bit 0) is 1. It moves once every PSC+1 ticks on tick_in, and a step occurs on a tick when the prescale counter is at or above the working divisor. Ticks while run is 0 change nothing.
- R3: In mode 00 (up), each step adds one. A step taken at or above the working limit sets the counter to 0 and raises an update.
- R4: In mode 01 (down), each step subtracts one. A step taken at 0 loads the holding reload limit and raises an update. dir_out is 1 after a step in this mode.
- R5: In mode 10 (center), the counter rises to the working limit, then falls to 0. Each turnaround raises an update. At the top the count goes to limit-1, and at the bottom it goes to 1 (to 0 when the limit is 0). dir_out is 1 while falling.
- R6: Writes to the prescale divisor (select 1) and the reload limit (select 2) change only the holding registers. The working registers take the holding values on the edge of an update event.
- R7: Writing the control word with bit 3 set causes an update on the following edge. It loads 0, or the holding limit in down mode, and clears the prescale counter. It also loads the working registers, sets dir_out to 1 in down mode and to 0 otherwise, and takes priority over a step.
- R8: trig_out pulses for one cycle, one cycle after every update event, in step with upd_out.
- R9: upd_out is a registered pulse, high for exactly the cycle after each update event and low otherwise.
- R10: Mode 11 behaves exactly like mode 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 prescale, 2 reload limit, 3 ignored |
| wr_data | input | 16 | Write data |
| tick_in | input | 1 | Count-enable tick fed to the prescaler |
| count_out | output | 16 | Current counter value |
| dir_out | output | 1 | 1 when the counter is moving downward |
| upd_out | output | 1 | Update pulse |
| trig_out | output | 1 | Trigger output for other blocks |

## Verification
The bench goes after the edges of the counting cycle. These are wrap at the limit, reload at zero, and the two turnarounds of the center sweep. A design that is off by one there would show a count of limit+1, or repeat the turning value twice. A new reload limit is written in the middle of a cycle and must not act until the next update. A design without proper holding registers would wrap early or late. The bench also checks the prescaler phase after an update request, and that ticks are ignored while stopped. A slipped phase shows up as a step one tick early, and a leaky run gate shows up as a moving count. A long random run mixes writes, ticks and mode changes, and compares every output against a behavioural model on every cycle.

// File: rtl/utmr_pkg.sv
package utmr_pkg;

  typedef enum logic [1:0] {
    CM_UP     = 2'd0,
    CM_DOWN   = 2'd1,
    CM_CENTER = 2'd2,
    CM_UPALT  = 2'd3
  } cmode_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_PSC  = 2'd1;
  localparam logic [1:0] SEL_ARR  = 2'd2;

  localparam int CTL_RUN  = 0;
  localparam int CTL_MODE = 1;
  localparam int CTL_UG   = 3;

endpackage

// File: rtl/utmr_regs.sv
module utmr_regs
  import utmr_pkg::*;
#(
  parameter int DAT_W = 16,
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter logic [CNT_W-1:0] RST_ARR = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             upd_evt,
  output logic             run_q,
  output cmode_e           mode_q,
  output logic             ug_req,
  output logic [PSC_W-1:0] psc_act,
  output logic [CNT_W-1:0] arr_act,
  output logic [CNT_W-1:0] arr_shd
);

  logic [PSC_W-1:0] psc_shd;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      mode_q  <= CM_UP;
      ug_req  <= 1'b0;
      psc_shd <= '0;
      psc_act <= '0;
      arr_shd <= RST_ARR;
      arr_act <= RST_ARR;
    end else begin
      ug_req <= 1'b0;
      if (upd_evt) begin
        psc_act <= psc_shd;
        arr_act <= arr_shd;
      end
      if (wr_en) begin
        case (wr_sel)
          SEL_CTRL: begin
            run_q  <= wr_data[CTL_RUN];
            mode_q <= cmode_e'(wr_data[CTL_MODE +: 2]);
            ug_req <= wr_data[CTL_UG];
          end
          SEL_PSC: psc_shd <= wr_data[PSC_W-1:0];
          SEL_ARR: arr_shd <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/utmr_presc.sv
module utmr_presc #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  input  logic             clr,
  input  logic [PSC_W-1:0] psc_act,
  output logic             step
);

  logic [PSC_W-1:0] pcnt_q;
  logic             at_top;

  assign at_top = (pcnt_q >= psc_act);
  assign step   = tick && run && at_top && !clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
    end else if (clr) begin
      pcnt_q <= '0;
    end else if (tick && run) begin
      if (at_top) pcnt_q <= '0;
      else        pcnt_q <= pcnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/utmr_count.sv
module utmr_count
  import utmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  cmode_e           mode,
  input  logic [CNT_W-1:0] arr_act,
  input  logic [CNT_W-1:0] arr_shd,
  output logic [CNT_W-1:0] cnt_q,
  output logic             dir_q,
  output logic             wrap
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_n;
  logic             dir_n;
  logic             lim_zero;

  assign lim_zero = (arr_act == '0);

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    wrap  = 1'b0;
    if (load) begin
      cnt_n = (mode == CM_DOWN) ? arr_shd : '0;
      dir_n = (mode == CM_DOWN);
    end else if (step) begin
      case (mode)
        CM_DOWN: begin
          dir_n = 1'b1;
          if (cnt_q == '0) begin
            cnt_n = arr_shd;
            wrap  = 1'b1;
          end else begin
            cnt_n = cnt_q - ONE;
          end
        end
        CM_CENTER: begin
          if (!dir_q) begin
            if (cnt_q >= arr_act) begin
              cnt_n = lim_zero ? '0 : arr_act - ONE;
              dir_n = 1'b1;
              wrap  = 1'b1;
            end else begin
              cnt_n = cnt_q + ONE;
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_n = lim_zero ? '0 : ONE;
              dir_n = 1'b0;
              wrap  = 1'b1;
            end else begin
              cnt_n = cnt_q - ONE;
            end
          end
        end
        default: begin
          dir_n = 1'b0;
          if (cnt_q >= arr_act) begin
            cnt_n = '0;
            wrap  = 1'b1;
          end else begin
            cnt_n = cnt_q + ONE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

endmodule

// File: rtl/utmr_core.sv
module utmr_core
  import utmr_pkg::*;
#(
  parameter int DAT_W = 16,
  parameter int CNT_W = 16,
  parameter int PSC_W = 16,
  parameter logic [CNT_W-1:0] RST_ARR = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             tick_in,
  output logic [CNT_W-1:0] count_out,
  output logic             dir_out,
  output logic             upd_out,
  output logic             trig_out
);

  logic             run_q;
  cmode_e           mode_q;
  logic             ug_req;
  logic [PSC_W-1:0] psc_act;
  logic [CNT_W-1:0] arr_act;
  logic [CNT_W-1:0] arr_shd;
  logic             step;
  logic             wrap;
  logic             upd_evt;

  assign upd_evt = wrap || ug_req;

  utmr_regs #(
    .DAT_W(DAT_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .RST_ARR(RST_ARR)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .upd_evt(upd_evt), .run_q(run_q), .mode_q(mode_q), .ug_req(ug_req),
    .psc_act(psc_act), .arr_act(arr_act), .arr_shd(arr_shd)
  );

  utmr_presc #(.PSC_W(PSC_W)) u_presc (
    .clk(clk), .rst(rst), .tick(tick_in), .run(run_q), .clr(ug_req),
    .psc_act(psc_act), .step(step)
  );

  utmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .step(step), .load(ug_req), .mode(mode_q),
    .arr_act(arr_act), .arr_shd(arr_shd), .cnt_q(count_out), .dir_q(dir_out),
    .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_out  <= 1'b0;
      trig_out <= 1'b0;
    end else begin
      upd_out  <= upd_evt;
      trig_out <= upd_evt;
    end
  end

endmodule

// File: rtl/utmr_core_chk.sv
module utmr_core_chk
  import utmr_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] count_out,
  input logic             upd_out,
  input logic             trig_out,
  input logic             step,
  input logic             ug_req,
  input logic             upd_evt,
  input cmode_e           mode_q,
  input logic [CNT_W-1:0] arr_act,
  input logic [PSC_W-1:0] psc_act
);

  // R3
  up_incr_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !ug_req && mode_q == CM_UP && count_out < arr_act)
      |=> count_out == $past(count_out) + 1'b1);

  // R4
  down_decr_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !ug_req && mode_q == CM_DOWN && count_out != '0)
      |=> count_out == $past(count_out) - 1'b1);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !ug_req) |=> $stable(count_out));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd_evt |=> ($stable(arr_act) && $stable(psc_act)));

  // R9
  upd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    upd_evt |=> upd_out);

  // R8
  trig_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    upd_evt |=> trig_out);

  // R7
  ug_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (ug_req && mode_q == CM_UP) |=> count_out == '0);

endmodule

bind utmr_core utmr_core_chk #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (.*);

// File: tb/utmr_core_test.sv
module utmr_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        tick_in = 1'b0;
  logic [15:0] count_out;
  logic        dir_out, upd_out, trig_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  utmr_core uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick_in(tick_in), .count_out(count_out), .dir_out(dir_out),
    .upd_out(upd_out), .trig_out(trig_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_cnt, m_pcnt, m_psc_a, m_psc_s, m_arr_a, m_arr_s, m_mode;
  bit m_run, m_dir, m_upd, m_ug;
  int n_cnt, n_pcnt;
  bit n_dir, evt, stp;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pcnt = 0; m_psc_a = 0; m_psc_s = 0;
      m_arr_a = 65535; m_arr_s = 65535; m_mode = 0;
      m_run = 0; m_dir = 0; m_upd = 0; m_ug = 0;
    end else begin
      n_cnt = m_cnt; n_pcnt = m_pcnt; n_dir = m_dir; evt = 0; stp = 0;
      if (m_ug) begin
        n_pcnt = 0;
        n_cnt = (m_mode == 1) ? m_arr_s : 0;
        n_dir = (m_mode == 1);
        evt = 1;
      end else begin
        if (tick_in && m_run) begin
          if (m_pcnt >= m_psc_a) begin stp = 1; n_pcnt = 0; end
          else n_pcnt = m_pcnt + 1;
        end
        if (stp) begin
          if (m_mode == 1) begin
            n_dir = 1;
            if (m_cnt == 0) begin n_cnt = m_arr_s; evt = 1; end
            else n_cnt = m_cnt - 1;
          end else if (m_mode == 2) begin
            if (!m_dir) begin
              if (m_cnt >= m_arr_a) begin
                n_cnt = (m_arr_a == 0) ? 0 : m_arr_a - 1; n_dir = 1; evt = 1;
              end else n_cnt = m_cnt + 1;
            end else begin
              if (m_cnt == 0) begin
                n_cnt = (m_arr_a == 0) ? 0 : 1; n_dir = 0; evt = 1;
              end else n_cnt = m_cnt - 1;
            end
          end else begin
            n_dir = 0;
            if (m_cnt >= m_arr_a) begin n_cnt = 0; evt = 1; end
            else n_cnt = m_cnt + 1;
          end
        end
      end
      if (evt) begin m_psc_a = m_psc_s; m_arr_a = m_arr_s; end
      m_cnt = n_cnt; m_pcnt = n_pcnt; m_dir = n_dir; m_upd = evt;
      m_ug = 0;
      if (wr_en) begin
        if (wr_sel == 0) begin
          m_run = wr_data[0]; m_mode = int'(wr_data[2:1]); m_ug = wr_data[3];
        end else if (wr_sel == 1) m_psc_s = int'(wr_data);
        else if (wr_sel == 2) m_arr_s = int'(wr_data);
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (m_mode == 1)      chk("R4 count", int'(count_out), m_cnt);
      else if (m_mode == 2) chk("R5 count", int'(count_out), m_cnt);
      else                  chk("R3 count", int'(count_out), m_cnt);
      chk("R5 dir", int'(dir_out), int'(m_dir));
      chk("R9 upd", int'(upd_out), int'(m_upd));
      chk("R8 trig", int'(trig_out), int'(m_upd));
    end
  end

  task automatic wr(input logic [1:0] s, input logic [15:0] d);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk("R1 count", int'(count_out), 0);
    chk("R1 dir", int'(dir_out), 0);
    chk("R1 upd", int'(upd_out), 0);
    chk("R1 trig", int'(trig_out), 0);

    // update request in down mode exposes the reset reload limit
    wr(2'd0, 16'd10);
    @(negedge clk);
    chk("R1 reset limit", int'(count_out), 65535);
    chk("R7 upd", int'(upd_out), 1);

    // up mode, limit 3
    wr(2'd2, 16'd3);
    wr(2'd1, 16'd0);
    wr(2'd0, 16'd9);
    @(negedge clk);
    chk("R7 up reload", int'(count_out), 0);

    // new limit held in shadow until the wrap
    wr(2'd2, 16'd7);
    ticks(4);
    chk("R6 old limit wrap", int'(count_out), 0);
    chk("R6 upd", int'(upd_out), 1);
    ticks(4);
    chk("R6 new limit active", int'(count_out), 4);

    // prescaler divide by 3
    wr(2'd1, 16'd2);
    wr(2'd0, 16'd9);
    @(negedge clk);
    ticks(6);
    chk("R2 divide", int'(count_out), 2);
    wr(2'd0, 16'd0);
    ticks(5);
    chk("R2 stopped", int'(count_out), 2);

    // mode 11 behaves as up
    wr(2'd1, 16'd0);
    wr(2'd0, 16'd15);
    @(negedge clk);
    ticks(3);
    chk("R10 alt up", int'(count_out), 3);

    // center mode, limit 2
    wr(2'd2, 16'd2);
    wr(2'd0, 16'd13);
    @(negedge clk);
    chk("R5 start", int'(count_out), 0);
    ticks(3);
    chk("R5 top turn", int'(count_out), 1);
    chk("R5 dir down", int'(dir_out), 1);
    chk("R5 top upd", int'(upd_out), 1);
    ticks(1);
    chk("R5 falling", int'(count_out), 0);
    ticks(1);
    chk("R5 bottom turn", int'(count_out), 1);
    chk("R5 dir up", int'(dir_out), 0);
    chk("R5 bottom upd", int'(upd_out), 1);

    // down mode, limit 9
    wr(2'd2, 16'd9);
    wr(2'd0, 16'd11);
    @(negedge clk);
    chk("R7 down reload", int'(count_out), 9);
    chk("R7 dir", int'(dir_out), 1);
    ticks(2);
    chk("R4 decrement", int'(count_out), 7);
    ticks(7);
    chk("R4 at zero", int'(count_out), 0);
    ticks(1);
    chk("R4 reload", int'(count_out), 9);
    chk("R8 trig", int'(trig_out), 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      tick_in = ($urandom % 4) != 0;
      if (($urandom % 8) == 0) begin
        wr_en = 1'b1;
        wr_sel = 2'($urandom % 4);
        case (wr_sel)
          2'd0: wr_data = {12'd0, (($urandom % 4) == 0), 2'($urandom % 4),
                           (($urandom % 6) != 0)};
          2'd1: wr_data = 16'($urandom % 4);
          default: wr_data = 16'($urandom % 10);
        endcase
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    tick_in = 1'b0;
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule